// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

This block is a register-level slave that hands out read-only configuration items to a host. Each item is a short byte string held in an internal computed ROM, together with its own length. The host first loads a 16-bit key into a selector, which names one item; it then pulls the item's bytes in order through a data register, taking one to eight bytes per access. A byte offset inside the block follows the host's progress through the item. Unknown keys and reads past the end return zeros rather than an error, so firmware can probe for items without any fault handling.

Two port layouts are available through a parameter. In the split layout the selector and data registers are separate ports. In the combined narrow layout a single port serves both, and the access size tells them apart. Every access gets a registered response one cycle later. An access the layout does not allow returns zero, changes nothing and raises a one-cycle error strobe.

Top module: `kc_item_port`

## Requirements
- R1: After reset, or after reset is asserted together with any access, key 0 is selected at offset zero, and all three response outputs are low. Key 0 in bank 0 holds the 4-byte signature 0x4B 0x43 0x46 0x47, so a 4-byte read returns 0x4B434647.
- R2: A selector write sets the byte offset to zero, even when it names the item already selected, so the next read starts again at the item's first byte.
- R3: The index field is bits 14:0 of the key. An index of NUM_ENTRIES (8) or more, including any key with bit 14 set, makes the selection invalid, and every later data read returns zero.
- R4: Key bit 15 picks bank 1 over bank 0. Apart from key 0 in bank 0, the item at bank b and index i has length (5*i + 3*b) mod 17, or 0 for i = 7. Its byte at offset k is {b, i[2:0], k[3:0]}.
- R5: An N-byte read (N from 1 to 8) returns the byte at the current offset in rsp_rdata[8N-1:8N-8] and each later byte in the next lower byte. Bits above 8N are zero. rsp_valid is high in the cycle after every access.
- R6: When fewer than N bytes remain, the bytes after the item's end are zero, and the offset advances only by the number of bytes delivered.
- R7: A read with the offset at the item length returns zero and leaves the offset unchanged.
- R8: An item of length zero reads as zero from the start.
- R9: A data write returns zero, raises no error and leaves both the selection and the offset unchanged.
- R10: In the combined layout (COMBINED=1), acc_port is ignored. A 1-byte read or write goes to the data register, a 2-byte write loads the selector, and every other access is rejected.
- R11: In the split layout (COMBINED=0), the control port (acc_port=0) accepts only 2-byte writes, and the data port (acc_port=1) accepts sizes 1 to 8. Any other access is rejected.
- R12: A rejected access returns zero data, raises acc_err for exactly one cycle and changes neither the selection nor the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_port | input | 1 | Split layout: 0 = control, 1 = data |
| acc_size | input | 4 | Access size in bytes |
| acc_wdata | input | 16 | Write data; the key on a selector write |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | 64 | Read data, right-aligned to the access size |
| acc_err | output | 1 | One-cycle strobe for a rejected access |

## Verification
A synchronous reset and a selector write can fall in the same cycle, and only one of them can set the selection. The bench holds rst_n low while it presents a control-port write of key 3. After release it reads four bytes and expects the signature, so the reset selection must win and the write must leave no trace. A second overlap is a read that both runs off the end of an item and sets the new offset. The bench judges it by the zero padding in the response and by the zero returned from the read that follows.

// File: rtl/kc_pkg.sv
// Shared types for the keyed configuration item read port.
// Assumes nothing beyond IEEE 1800-2017 packages.
package kc_pkg;
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_SEL,
        OP_READ,
        OP_DWR,
        OP_REJ
    } kc_op_e;

    localparam logic [31:0] KC_SIG_DEFAULT = 32'h4B434647;
endpackage

// File: rtl/kc_decode.sv
// Access decoder: sorts one host access into select, data read, data write
// or reject. The port layout is fixed by the COMBINED parameter.
// Assumes at most one access per cycle; acc_size is a byte count.
module kc_decode
    import kc_pkg::*;
#(
    parameter bit COMBINED = 1'b0,
    parameter int LANES    = 8,
    localparam int SIZE_W  = $clog2(LANES + 1)
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_port,
    input  logic [SIZE_W-1:0] acc_size,
    output kc_op_e            op
);
    generate
        if (COMBINED) begin : g_comb
            // Single narrow port: the access size picks the register.
            always_comb begin
                op = OP_IDLE;
                if (acc_valid) begin
                    if (acc_size == SIZE_W'(1))
                        op = acc_write ? OP_DWR : OP_READ;
                    else if (acc_size == SIZE_W'(2) && acc_write)
                        op = OP_SEL;
                    else
                        op = OP_REJ;
                end
            end
        end else begin : g_split
            // Separate control and data ports.
            always_comb begin
                op = OP_IDLE;
                if (acc_valid) begin
                    if (!acc_port)
                        op = (acc_write && acc_size == SIZE_W'(2)) ? OP_SEL : OP_REJ;
                    else if (int'(acc_size) >= 1 && int'(acc_size) <= LANES)
                        op = acc_write ? OP_DWR : OP_READ;
                    else
                        op = OP_REJ;
                end
            end
        end
    endgenerate

    // A selector load only ever comes from a 2-byte write (R10, R11).
    always_comb begin
        if (op == OP_SEL)
            p_sel_shape_r10: assert (acc_write && acc_size == SIZE_W'(2));
    end
endmodule

// File: rtl/kc_rom.sv
// Computed item store: returns the length of the addressed item and the
// bytes at LANES consecutive offsets starting at the base offset.
// Assumes IDX_W >= 3 and MAX_LEN >= 4; bytes beyond an item's length are
// don't-care here (the packer masks them).
module kc_rom #(
    parameter int          NUM_ENTRIES = 8,
    parameter int          IDX_W       = 15,
    parameter int          MAX_LEN     = 16,
    parameter int          LANES       = 8,
    parameter logic [31:0] SIGNATURE   = kc_pkg::KC_SIG_DEFAULT,
    localparam int         OFF_W       = $clog2(MAX_LEN + 1)
) (
    input  logic                  bank,
    input  logic [IDX_W-1:0]      idx,
    input  logic [OFF_W-1:0]      base,
    output logic [OFF_W-1:0]      len,
    output logic [LANES-1:0][7:0] lane_byte
);
    // Content of one item byte.
    function automatic logic [7:0] item_byte(logic b, logic [IDX_W-1:0] i, int k);
        if (!b && i == '0)
            return (k < 4) ? SIGNATURE[8*(3-k) +: 8] : 8'h00;
        return {b, i[2:0], k[3:0]};
    endfunction

    // Length of the addressed item.
    always_comb begin
        if (!bank && idx == '0)
            len = OFF_W'(4);
        else if (int'(idx) == NUM_ENTRIES - 1)
            len = '0;
        else
            len = OFF_W'((5 * int'(idx) + 3 * int'(bank)) % (MAX_LEN + 1));
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_byte[l] = item_byte(bank, idx, int'(base) + l);
    end
endmodule

// File: rtl/kc_pack.sv
// Read packer: places the first deliverable byte in the most significant
// byte of an N-byte access and zero-fills whatever the item cannot supply.
// Assumes avail is already zero for an invalid or exhausted selection.
module kc_pack #(
    parameter int  LANES  = 8,
    parameter int  OFF_W  = 5,
    localparam int SIZE_W = $clog2(LANES + 1),
    localparam int DATA_W = 8 * LANES
) (
    input  logic [LANES-1:0][7:0] lane_byte,
    input  logic [SIZE_W-1:0]     size,
    input  logic [OFF_W-1:0]      avail,
    output logic [DATA_W-1:0]     data,
    output logic [OFF_W-1:0]      take
);
    // Count the delivered bytes and align them to the access size.
    always_comb begin
        int n;
        n = (int'(size) < int'(avail)) ? int'(size) : int'(avail);
        if (n > LANES)
            n = LANES;
        take = OFF_W'(n);
        data = '0;
        for (int l = 0; l < LANES; l++) begin
            if (l < n && (int'(size) - 1 - l) < LANES)
                data[8*(int'(size)-1-l) +: 8] = lane_byte[l];
        end
    end
endmodule

// File: rtl/kc_item_port.sv
// Keyed configuration item read port (top). Holds the selected key, the
// validity of the selection and the byte offset, and registers one response
// per access. Assumes key bit KEY_W-1 is the bank bit and the rest is index.
module kc_item_port
    import kc_pkg::*;
#(
    parameter bit          COMBINED    = 1'b0,
    parameter int          KEY_W       = 16,
    parameter int          NUM_ENTRIES = 8,
    parameter int          MAX_LEN     = 16,
    parameter int          LANES       = 8,
    parameter logic [31:0] SIGNATURE   = KC_SIG_DEFAULT,
    localparam int         IDX_W       = KEY_W - 1,
    localparam int         OFF_W       = $clog2(MAX_LEN + 1),
    localparam int         SIZE_W      = $clog2(LANES + 1),
    localparam int         DATA_W      = 8 * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_port,
    input  logic [SIZE_W-1:0] acc_size,
    input  logic [KEY_W-1:0]  acc_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              acc_err
);
    kc_op_e                op;
    logic                  sel_bank;
    logic [IDX_W-1:0]      sel_idx;
    logic                  sel_ok;
    logic [OFF_W-1:0]      offset;
    logic [OFF_W-1:0]      cur_len;
    logic [OFF_W-1:0]      avail;
    logic [OFF_W-1:0]      take;
    logic [LANES-1:0][7:0] lane_byte;
    logic [DATA_W-1:0]     packed_data;

    kc_decode #(.COMBINED(COMBINED), .LANES(LANES)) u_dec (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_port  (acc_port),
        .acc_size  (acc_size),
        .op        (op)
    );

    kc_rom #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .IDX_W       (IDX_W),
        .MAX_LEN     (MAX_LEN),
        .LANES       (LANES),
        .SIGNATURE   (SIGNATURE)
    ) u_rom (
        .bank      (sel_bank),
        .idx       (sel_idx),
        .base      (offset),
        .len       (cur_len),
        .lane_byte (lane_byte)
    );

    // Bytes still deliverable from the current selection.
    always_comb begin
        avail = (sel_ok && offset < cur_len) ? cur_len - offset : '0;
    end

    kc_pack #(.LANES(LANES), .OFF_W(OFF_W)) u_pack (
        .lane_byte (lane_byte),
        .size      (acc_size),
        .avail     (avail),
        .data      (packed_data),
        .take      (take)
    );

    // Selection, offset and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_bank  <= 1'b0;
            sel_idx   <= '0;
            sel_ok    <= 1'b1;
            offset    <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            acc_err   <= 1'b0;
        end else begin
            rsp_valid <= (op != OP_IDLE);
            acc_err   <= (op == OP_REJ);
            rsp_rdata <= (op == OP_READ) ? packed_data : '0;
            case (op)
                OP_SEL: begin
                    sel_bank <= acc_wdata[KEY_W-1];
                    sel_idx  <= acc_wdata[IDX_W-1:0];
                    sel_ok   <= (int'(acc_wdata[IDX_W-1:0]) < NUM_ENTRIES);
                    offset   <= '0;
                end
                OP_READ: offset <= offset + take;
                default: ;
            endcase
        end
    end

    // R2: a selector load rewinds the offset.
    p_sel_rewind_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SEL) |=> (offset == '0));

    // R7: the offset never passes the selected item's end.
    p_off_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ok |-> (offset <= cur_len));

    // R3: an invalid selection reads as zero.
    p_invalid_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ok && op == OP_READ) |=> (rsp_rdata == '0));

    // R12: a rejected access flags an error and keeps all state.
    p_reject_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_REJ) |=> (acc_err && rsp_rdata == '0 && $stable(offset)
                            && $stable(sel_idx) && $stable(sel_bank)));

    // R9: a data write leaves the offset alone and is not an error.
    p_dwrite_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DWR) |=> ($stable(offset) && !acc_err && rsp_rdata == '0));

    // R6: a read never consumes more bytes than remain.
    p_take_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_READ) |-> (take <= avail));

    // R5: every access is answered in the next cycle.
    p_resp_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_IDLE) |=> rsp_valid);
endmodule

// File: tb/sim_kc_item_port.sv
module sim_kc_item_port;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        port;
        logic        wr;
        logic [3:0]  size;
        logic [15:0] key;
        logic [63:0] exp;
        logic        err;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VT [NV] = '{
        '{1'b1, 1'b0, 4'd4, 16'h0000, 64'h4B434647,         1'b0}, // R1 signature
        '{1'b1, 1'b0, 4'd1, 16'h0000, 64'h0,                1'b0}, // R7 exhausted
        '{1'b0, 1'b1, 4'd2, 16'h0001, 64'h0,                1'b0}, // R2 select
        '{1'b1, 1'b0, 4'd2, 16'h0000, 64'h1011,             1'b0}, // R5 order
        '{1'b1, 1'b1, 4'd1, 16'h00FF, 64'h0,                1'b0}, // R9 ignored
        '{1'b1, 1'b0, 4'd8, 16'h0000, 64'h1213140000000000, 1'b0}, // R6 padding
        '{1'b1, 1'b0, 4'd4, 16'h0000, 64'h0,                1'b0}, // R7 past end
        '{1'b0, 1'b1, 4'd2, 16'h8003, 64'h0,                1'b0}, // R4 bank 1
        '{1'b1, 1'b0, 4'd3, 16'h0000, 64'hB00000,           1'b0}, // R4 content
        '{1'b0, 1'b1, 4'd2, 16'h0008, 64'h0,                1'b0}, // R3 invalid
        '{1'b1, 1'b0, 4'd8, 16'h0000, 64'h0,                1'b0}, // R3 zeros
        '{1'b0, 1'b1, 4'd2, 16'h0007, 64'h0,                1'b0}, // R8 select
        '{1'b1, 1'b0, 4'd2, 16'h0000, 64'h0,                1'b0}, // R8 empty
        '{1'b0, 1'b1, 4'd2, 16'h8006, 64'h0,                1'b0}, // R4 select
        '{1'b1, 1'b0, 4'd8, 16'h0000, 64'hE0E1E2E3E4E5E6E7, 1'b0}, // R5 full
        '{1'b0, 1'b1, 4'd2, 16'h8006, 64'h0,                1'b0}, // R2 reselect
        '{1'b1, 1'b0, 4'd2, 16'h0000, 64'hE0E1,             1'b0}, // R2 rewound
        '{1'b0, 1'b0, 4'd2, 16'h0000, 64'h0,                1'b1}, // R11 ctl read
        '{1'b0, 1'b1, 4'd1, 16'h0001, 64'h0,                1'b1}, // R11 ctl byte
        '{1'b1, 1'b0, 4'd0, 16'h0000, 64'h0,                1'b1}, // R11 size 0
        '{1'b1, 1'b0, 4'd9, 16'h0000, 64'h0,                1'b1}, // R11 size 9
        '{1'b1, 1'b0, 4'd1, 16'h0000, 64'hE2,               1'b0}, // R12 kept
        '{1'b0, 1'b1, 4'd2, 16'h4001, 64'h0,                1'b0}, // R3 bit 14
        '{1'b1, 1'b0, 4'd1, 16'h0000, 64'h0,                1'b0}, // R3 zeros
        '{1'b0, 1'b1, 4'd2, 16'h8000, 64'h0,                1'b0}  // R4 bank1 idx0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        v0 = 1'b0;
    logic        v1 = 1'b0;
    logic        a_wr = 1'b0;
    logic        a_port = 1'b0;
    logic [3:0]  a_size = 4'd0;
    logic [15:0] a_wdata = 16'h0;
    logic        rv0, er0, rv1, er1;
    logic [63:0] rd0, rd1;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kc_item_port #(.COMBINED(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(v0), .acc_write(a_wr),
        .acc_port(a_port), .acc_size(a_size), .acc_wdata(a_wdata),
        .rsp_valid(rv0), .rsp_rdata(rd0), .acc_err(er0)
    );

    kc_item_port #(.COMBINED(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .acc_valid(v1), .acc_write(a_wr),
        .acc_port(a_port), .acc_size(a_size), .acc_wdata(a_wdata),
        .rsp_valid(rv1), .rsp_rdata(rd1), .acc_err(er1)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One access on instance inst; outputs are sampled one clock later.
    task automatic acc(int inst, logic port, logic wr, logic [3:0] size, logic [15:0] key);
        @(negedge clk);
        a_port = port; a_wr = wr; a_size = size; a_wdata = key;
        v0 = (inst == 0); v1 = (inst == 1);
        @(negedge clk);
        v0 = 1'b0; v1 = 1'b0;
    endtask

    // Response check for instance 1 (combined layout).
    task automatic chk1(string req, logic [63:0] exp, logic err);
        chk(req, {63'h0, rv1}, 64'h1);
        chk(req, rd1, exp);
        chk(req, {63'h0, er1}, {63'h0, err});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state of the outputs
        chk("R1 rsp_valid", {63'h0, rv0}, 64'h0);
        chk("R1 rdata", rd0, 64'h0);
        chk("R1 err", {63'h0, er0}, 64'h0);
        rst_n = 1'b1;

        // Table walk on the split layout
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("vector %0d", i);
            acc(0, VT[i].port, VT[i].wr, VT[i].size, VT[i].key);
            chk(tag, {63'h0, rv0}, 64'h1);
            chk(tag, rd0, VT[i].exp);
            chk(tag, {63'h0, er0}, {63'h0, VT[i].err});
        end
        // R4 R6: bank 1 index 0 has three bytes 0x80..0x82
        acc(0, 1'b1, 1'b0, 4'd4, 16'h0);
        chk("R4 R6 bank1 idx0", rd0, 64'h80818200);

        // R12: error strobe lasts one cycle
        acc(0, 1'b0, 1'b0, 4'd1, 16'h0);
        chk("R12 strobe", {63'h0, er0}, 64'h1);
        @(negedge clk);
        chk("R12 strobe drop", {63'h0, er0}, 64'h0);

        // R10: combined layout on instance u1
        acc(1, 1'b1, 1'b0, 4'd1, 16'h0);  chk1("R10 byte read", 64'h4B, 1'b0);
        acc(1, 1'b0, 1'b0, 4'd1, 16'h0);  chk1("R10 port ignored", 64'h43, 1'b0);
        acc(1, 1'b1, 1'b1, 4'd2, 16'h0001); chk1("R10 select", 64'h0, 1'b0);
        acc(1, 1'b0, 1'b0, 4'd1, 16'h0);  chk1("R10 after select", 64'h10, 1'b0);
        acc(1, 1'b0, 1'b1, 4'd1, 16'h00AA); chk1("R10 R9 data write", 64'h0, 1'b0);
        acc(1, 1'b0, 1'b0, 4'd1, 16'h0);  chk1("R10 R9 offset kept", 64'h11, 1'b0);
        acc(1, 1'b0, 1'b0, 4'd2, 16'h0);  chk1("R10 2-byte read rejected", 64'h0, 1'b1);
        acc(1, 1'b0, 1'b1, 4'd4, 16'h0003); chk1("R10 4-byte write rejected", 64'h0, 1'b1);
        acc(1, 1'b0, 1'b0, 4'd1, 16'h0);  chk1("R10 R12 state kept", 64'h12, 1'b0);

        // R1: reset wins over a selector write in the same cycle
        @(negedge clk);
        rst_n = 1'b0;
        a_port = 1'b0; a_wr = 1'b1; a_size = 4'd2; a_wdata = 16'h0003; v0 = 1'b1;
        @(negedge clk);
        v0 = 1'b0;
        rst_n = 1'b1;
        chk("R1 reset response", {63'h0, rv0}, 64'h0);
        acc(0, 1'b1, 1'b0, 4'd4, 16'h0);
        chk("R1 reset over select", rd0, 64'h4B434647);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): got hang expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule